// File: doc/BRIEF.md
# FSK Fractional Numerator Modulator

This block sits ahead of the fractional-N divider of a frequency synthesizer. Each clock cycle it computes the fractional numerator and integer divide value to apply. The result is a nominal base numerator plus a signed deviation, counted in numerator steps. One step moves the synthesized frequency by the phase-detector frequency divided by the fractional denominator. A deviation of k steps therefore shifts the output by k such increments. Negative deviations are held as 16-bit two's complement words. For example, 64178 stands for −1358 steps.

The deviation comes from one of four sources, chosen by a mode field:
- **Pin mode:** data pins carry a symbol that indexes a table of stored deviations.
- **Index mode:** a table index written to a register.
- **Fast mode:** a deviation word written directly.
- **Serial mode:** a 16-bit word clocked in bit by bit on a serial data/clock/frame input.

Two frequency profiles each hold their own eight-entry table and their own FSK enable. The sum is reduced modulo the denominator. A carry adjusts the integer value up by one and a borrow adjusts it down by one.

Top module: `fsk_num_mod`

## Requirements
- R1: Reset state.
  - While rst_ni is low and after its release, num_o, int_o and chg_o are 0.
  - All configuration registers are 0, except the denominator, which is all ones.
  - The serial word is 0.
- R2: Register map. A write with wr_en_i high stores wr_data_i at wr_addr_i:
  - Address 0 is control:
    - bits [1:0] select the mode: 00 pin, 01 index, 10 serial, 11 fast.
    - bits [3:2] hold the level L.
    - bit 4 enables profile 0 and bit 5 enables profile 1.
    - bit 6 selects the active profile.
    - bits [9:7] hold the table index.
  - Address 1 is the base numerator.
  - Address 2 is the denominator.
  - Address 3 is the base integer.
  - Address 4 is the fast deviation word.
  - Addresses 8+i and 16+i are entry i (0..7) of the tables of profile 0 and profile 1.
- R3: In pin mode the table entry is sym_i with every bit at position L and above forced to 0.
  - With L=2, symbol 00 selects entry 0, 01 entry 1, 10 entry 2 and 11 entry 3.
  - L=1 uses one bit, L=3 uses three bits, and L=0 always selects entry 0.
- R4: In index mode the control index field (0..7) selects the table entry, regardless of sym_i.
- R5: In fast mode the written 16-bit fast word is the deviation, unchanged.
- R6: Serial input:
  - ser_dat_i is shifted in most significant bit first, on each rising edge of ser_clk_i as sampled by clk_i.
  - On a rising edge of ser_frm_i, a frame of exactly 16 bits becomes the serial word used in serial mode.
  - Every rising frame edge restarts the bit count.
- R7: A frame edge after fewer or more than 16 bits leaves the serial word unchanged.
- R8: The active profile's table is used.
  - If the active profile's enable bit is 0, the deviation is zero in every mode.
  - In that case num_o and int_o equal the base numerator and base integer.
- R9: The 16-bit deviation is sign-extended and added to the base numerator.
  - A negative sum adds the denominator and gives integer base−1.
  - A sum at or above the denominator subtracts it and gives integer base+1.
  - Any other sum passes with integer base.
- R10: Timing and change flag.
  - num_o and int_o reflect the inputs and registers as they stand one clk_i edge earlier.
  - chg_o is high for exactly the cycles in which that edge gave num_o or int_o a new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 24 | Register write data |
| sym_i | input | 3 | Symbol pins for pin mode |
| ser_dat_i | input | 1 | Serial deviation data |
| ser_clk_i | input | 1 | Serial bit clock, sampled by clk_i |
| ser_frm_i | input | 1 | Serial frame sync, rising edge latches |
| num_o | output | 24 | Fractional numerator |
| int_o | output | 12 | Integer divide value |
| chg_o | output | 1 | Pulse when num_o or int_o changed |

## Verification
- **Symbol pins:** a symbol present before a clk_i edge shows on num_o and int_o right after that edge.
- **Register writes:** a write takes one edge to store and a second edge to reach the outputs.
- **Serial words:** a frame edge seen at one edge latches the word, and the output follows at the next.
- **General checks:** the bench drives on falling edges and waits at least two rising edges before sampling on a falling edge. All outputs have then settled.
- **Latency and chg_o:** the dedicated test samples one falling edge after a symbol change to see the new value with chg_o high. It samples one falling edge later to see chg_o low again.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

  typedef enum logic [1:0] {
    MODE_PIN  = 2'b00,
    MODE_IDX  = 2'b01,
    MODE_SER  = 2'b10,
    MODE_FAST = 2'b11
  } fsk_mode_e;

  typedef struct packed {
    logic [2:0] idx;
    logic       prof;
    logic [1:0] en;
    logic [1:0] lvl;
    fsk_mode_e  mode;
  } fsk_ctrl_t;

  localparam int CTRL_W    = $bits(fsk_ctrl_t);
  localparam int A_CTRL    = 0;
  localparam int A_BASE    = 1;
  localparam int A_DEN     = 2;
  localparam int A_INT     = 3;
  localparam int A_FAST    = 4;
  localparam int N_PROF    = 2;

endpackage

// File: rtl/fsk_cfg_regs.sv
module fsk_cfg_regs
  import fsk_pkg::*;
#(
  parameter int DEV_W  = 16,
  parameter int NUM_W  = 24,
  parameter int INT_W  = 12,
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 5
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  wr_en_i,
  input  logic [ADDR_W-1:0]                     wr_addr_i,
  input  logic [NUM_W-1:0]                      wr_data_i,
  output fsk_ctrl_t                             ctrl_o,
  output logic [NUM_W-1:0]                      base_num_o,
  output logic [NUM_W-1:0]                      den_o,
  output logic [INT_W-1:0]                      base_int_o,
  output logic [DEV_W-1:0]                      fast_o,
  output logic [N_PROF-1:0][N_ENT-1:0][DEV_W-1:0] tab_o
);

  localparam int TAB_BASE = N_ENT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= '0;
      base_num_o <= '0;
      den_o      <= '1;
      base_int_o <= '0;
      fast_o     <= '0;
    end else if (wr_en_i) begin
      case (int'(wr_addr_i))
        A_CTRL: ctrl_o     <= fsk_ctrl_t'(wr_data_i[CTRL_W-1:0]);
        A_BASE: base_num_o <= wr_data_i;
        A_DEN:  den_o      <= wr_data_i;
        A_INT:  base_int_o <= wr_data_i[INT_W-1:0];
        A_FAST: fast_o     <= wr_data_i[DEV_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < N_PROF; p++) begin : g_prof
    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      localparam int ENT_ADDR = TAB_BASE * (p + 1) + i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          tab_o[p][i] <= '0;
        else if (wr_en_i && int'(wr_addr_i) == ENT_ADDR)
          tab_o[p][i] <= wr_data_i[DEV_W-1:0];
      end
    end
  end

endmodule

// File: rtl/fsk_serial_rx.sv
module fsk_serial_rx #(
  parameter int DEV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdat_i,
  input  logic             sclk_i,
  input  logic             sfrm_i,
  output logic [DEV_W-1:0] word_o
);

  localparam int CNT_W = $clog2(DEV_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEV_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(DEV_W + 1);

  logic             sclk_q, sfrm_q;
  logic [DEV_W-1:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic             clk_rise, frm_rise;

  assign clk_rise = sclk_i & ~sclk_q;
  assign frm_rise = sfrm_i & ~sfrm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sfrm_q <= 1'b0;
      shreg  <= '0;
      cnt    <= '0;
      word_o <= '0;
    end else begin
      sclk_q <= sclk_i;
      sfrm_q <= sfrm_i;
      if (frm_rise) begin
        if (cnt == CNT_FULL) word_o <= shreg;
        cnt <= '0;
      end else if (clk_rise) begin
        shreg <= {shreg[DEV_W-2:0], sdat_i};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;  // saturate: over-long frame
      end
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_OVER);

  p_drop_bad_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_rise && cnt != CNT_FULL) |=> $stable(word_o));

  p_frame_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_rise |=> cnt == '0);

endmodule

// File: rtl/fsk_num_add.sv
module fsk_num_add #(
  parameter int DEV_W = 16,
  parameter int NUM_W = 24,
  parameter int INT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [NUM_W-1:0] base_num_i,
  input  logic [NUM_W-1:0] den_i,
  input  logic [INT_W-1:0] base_int_i,
  output logic [NUM_W-1:0] num_o,
  output logic [INT_W-1:0] int_o,
  output logic             chg_o
);

  localparam int SW = NUM_W + 2;

  logic signed [SW-1:0] sum, den_s, wrap_up, wrap_dn;
  logic [NUM_W-1:0]     nxt_num;
  logic [INT_W-1:0]     nxt_int;

  always_comb begin
    den_s   = $signed({2'b00, den_i});
    sum     = $signed({2'b00, base_num_i})
            + $signed({{(SW-DEV_W){dev_i[DEV_W-1]}}, dev_i});
    wrap_up = sum + den_s;
    wrap_dn = sum - den_s;
    if (sum[SW-1]) begin
      nxt_num = wrap_up[NUM_W-1:0];
      nxt_int = base_int_i - 1'b1;
    end else if (sum >= den_s) begin
      nxt_num = wrap_dn[NUM_W-1:0];
      nxt_int = base_int_i + 1'b1;
    end else begin
      nxt_num = sum[NUM_W-1:0];
      nxt_int = base_int_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_o <= '0;
      int_o <= '0;
      chg_o <= 1'b0;
    end else begin
      num_o <= nxt_num;
      int_o <= nxt_int;
      chg_o <= (nxt_num != num_o) || (nxt_int != int_o);
    end
  end

  p_int_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o == $past(base_int_i)) || (int_o == INT_W'($past(base_int_i) + 1'b1))
    || (int_o == INT_W'($past(base_int_i) - 1'b1)));

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg_o |-> ($stable(num_o) && $stable(int_o)));

endmodule

// File: rtl/fsk_num_mod.sv
module fsk_num_mod
  import fsk_pkg::*;
#(
  parameter int DEV_W  = 16,
  parameter int NUM_W  = 24,
  parameter int INT_W  = 12,
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 5,
  parameter int SYM_W  = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NUM_W-1:0]  wr_data_i,
  input  logic [SYM_W-1:0]  sym_i,
  input  logic              ser_dat_i,
  input  logic              ser_clk_i,
  input  logic              ser_frm_i,
  output logic [NUM_W-1:0]  num_o,
  output logic [INT_W-1:0]  int_o,
  output logic              chg_o
);

  fsk_ctrl_t                              ctrl;
  logic [NUM_W-1:0]                       base_num, den;
  logic [INT_W-1:0]                       base_int;
  logic [DEV_W-1:0]                       fast_w, ser_w, raw_dev, dev;
  logic [N_PROF-1:0][N_ENT-1:0][DEV_W-1:0] tab;
  logic [SYM_W:0]                         lvl_mask;
  logic [SYM_W-1:0]                       pin_idx;
  logic                                   en_act;

  fsk_cfg_regs #(
    .DEV_W(DEV_W), .NUM_W(NUM_W), .INT_W(INT_W), .N_ENT(N_ENT), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .base_num_o(base_num), .den_o(den), .base_int_o(base_int),
    .fast_o(fast_w), .tab_o(tab)
  );

  fsk_serial_rx #(.DEV_W(DEV_W)) u_ser (
    .clk_i, .rst_ni, .sdat_i(ser_dat_i), .sclk_i(ser_clk_i), .sfrm_i(ser_frm_i),
    .word_o(ser_w)
  );

  always_comb begin
    lvl_mask = ((SYM_W+1)'(1) << ctrl.lvl) - 1'b1;
    pin_idx  = sym_i & lvl_mask[SYM_W-1:0];
    en_act   = ctrl.en[ctrl.prof];
    case (ctrl.mode)
      MODE_PIN:  raw_dev = tab[ctrl.prof][pin_idx];
      MODE_IDX:  raw_dev = tab[ctrl.prof][ctrl.idx];
      MODE_SER:  raw_dev = ser_w;
      default:   raw_dev = fast_w;
    endcase
    dev = en_act ? raw_dev : '0;
  end

  fsk_num_add #(.DEV_W(DEV_W), .NUM_W(NUM_W), .INT_W(INT_W)) u_add (
    .clk_i, .rst_ni, .dev_i(dev), .base_num_i(base_num), .den_i(den),
    .base_int_i(base_int), .num_o, .int_o, .chg_o
  );

  p_off_base_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_act && base_num < den) |=> (num_o == $past(base_num) && int_o == $past(base_int)));

endmodule

// File: tb/tb_fsk_num_mod.sv
module tb_fsk_num_mod;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic [2:0]  sym = '0;
  logic        sdat = 1'b0, sclk = 1'b0, sfrm = 1'b0;
  logic [23:0] num;
  logic [11:0] intv;
  logic        chg;

  int checks = 0, errors = 0;

  // bench model of configuration
  logic [1:0]  m_mode = 2'b00, m_lvl = 2'd0, m_en = 2'b00;
  logic        m_prof = 1'b0;
  logic [2:0]  m_idx = 3'd0;
  logic [23:0] m_base = '0, m_den = '1;
  logic [11:0] m_int = '0;
  logic [15:0] m_fast = '0, m_ser = '0;
  logic [15:0] m_tab [2][8];

  fsk_num_mod dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .sym_i(sym), .ser_dat_i(sdat), .ser_clk_i(sclk),
    .ser_frm_i(sfrm), .num_o(num), .int_o(intv), .chg_o(chg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  task automatic wr(input int a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl();
    wr(0, 24'({m_idx, m_prof, m_en, m_lvl, m_mode}));
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_dev();
    logic [2:0] mask;
    if (!m_en[m_prof]) return '0;
    mask = 3'((4'd1 << m_lvl) - 4'd1);
    case (m_mode)
      2'b00:   return m_tab[m_prof][sym & mask];
      2'b01:   return m_tab[m_prof][m_idx];
      2'b10:   return m_ser;
      default: return m_fast;
    endcase
  endfunction

  function automatic logic [35:0] ref_out(input logic [15:0] d);
    longint s = longint'(m_base) + longint'($signed(d));
    logic [11:0] iv = m_int;
    if (s < 0) begin s += longint'(m_den); iv -= 12'd1; end
    else if (s >= longint'(m_den)) begin s -= longint'(m_den); iv += 12'd1; end
    return {iv, 24'(s)};
  endfunction

  task automatic chk(input string tag);
    logic [35:0] e = ref_out(exp_dev());
    checks++;
    if ({intv, num} !== e) begin
      errors++;
      $display("FAIL %s: actual int=%0d num=%0d, expected int=%0d num=%0d",
               tag, intv, num, e[35:24], e[23:0]);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0b, expected %0b", tag, act, expv);
    end
  endtask

  task automatic send_ser(input logic [31:0] w, input int n);
    for (int b = n - 1; b >= 0; b--) begin
      @(negedge clk); sdat = w[b]; sclk = 1'b0;
      @(negedge clk); sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
    end
    @(negedge clk); sfrm = 1'b1;
    @(negedge clk); sfrm = 1'b0;
    if (n == 16) m_ser = w[15:0];
    settle();
  endtask

  initial begin
    logic [15:0] fw [6];
    fw = '{16'd518, 16'd1357, 16'd64178, 16'd63857, 16'h8000, 16'h7FFF};
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (num !== '0 || intv !== '0 || chg !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: actual num=%0d int=%0d chg=%0b, expected 0 0 0", num, intv, chg);
    end
    rst_n = 1'b1;
    settle();
    checks++;
    if (num !== '0 || intv !== '0 || chg !== 1'b0) begin
      errors++;
      $display("FAIL R1 after release: actual num=%0d int=%0d chg=%0b, expected 0 0 0", num, intv, chg);
    end

    // R2: base registers and tables
    m_base = 24'd2000000; m_den = 24'd5000000; m_int = 12'd100;
    wr(1, m_base); wr(2, m_den); wr(3, 24'(m_int));
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 8; i++) begin
        m_tab[p][i] = (i < 4) ? 16'(100 * (i + 1) + 7 * p + 1)
                              : 16'(-(100 * (i - 3) + 7 * p + 3));
        wr(8 * (p + 1) + i, 24'(m_tab[p][i]));
      end
    settle();
    chk("R2 base after writes, mode pin disabled");

    // R3/R8: pin mode over profiles, enables, levels, symbols
    for (int p = 0; p < 2; p++)
      for (int e = 0; e < 4; e++)
        for (int l = 0; l < 4; l++) begin
          m_mode = 2'b00; m_prof = 1'(p); m_en = 2'(e); m_lvl = 2'(l);
          set_ctrl();
          for (int s = 0; s < 8; s++) begin
            @(negedge clk); sym = 3'(s);
            settle();
            chk(m_en[m_prof] ? "R3 pin-mode lookup" : "R8 disabled profile");
          end
        end

    // R4: index mode, sym must not matter
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 8; i++) begin
        m_mode = 2'b01; m_prof = 1'(p); m_en = 2'b11; m_idx = 3'(i); m_lvl = 2'd3;
        set_ctrl();
        @(negedge clk); sym = 3'(7 - i);
        settle();
        chk("R4 index-mode lookup");
      end

    // R5/R9: fast words with normal, carry and borrow bases
    m_mode = 2'b11; m_en = 2'b11; m_prof = 1'b0;
    set_ctrl();
    for (int b = 0; b < 3; b++) begin
      m_base = (b == 0) ? 24'd2000000 : (b == 1) ? m_den - 24'd100 : 24'd50;
      wr(1, m_base);
      for (int k = 0; k < 6; k++) begin
        m_fast = fw[k];
        wr(4, 24'(m_fast));
        settle();
        chk(b == 0 ? "R5 fast word" : "R9 wrap carry/borrow");
      end
    end
    m_en = 2'b10; set_ctrl(); settle();
    chk("R8 fast mode with active profile disabled");
    m_base = 24'd2000000; wr(1, m_base);

    // R10: latency and change pulse in pin mode
    m_mode = 2'b00; m_en = 2'b11; m_prof = 1'b1; m_lvl = 2'd2;
    set_ctrl();
    @(negedge clk); sym = 3'd0;
    settle();
    @(negedge clk); sym = 3'd3;
    @(negedge clk);
    chk("R10 output one edge after symbol");
    chk_bit("R10 chg_o pulse on change", chg, 1'b1);
    @(negedge clk);
    chk_bit("R10 chg_o low when steady", chg, 1'b0);

    // R6/R7: serial input
    m_mode = 2'b10; m_prof = 1'b0;
    set_ctrl();
    send_ser(32'h0000_0206, 16); chk("R6 serial word 518");
    send_ser(32'h0000_FAB2, 16); chk("R6 serial word 64178 MSB first");
    send_ser(32'h0000_0155, 10); chk("R7 short frame discarded");
    send_ser(32'h000A_BCDE, 20); chk("R7 long frame discarded");
    send_ser(32'h0000_8001, 16); chk("R6 serial word after bad frames");

    finish_run();
  end

endmodule